// File: doc/BRIEF.md
# Load Dependent Wakeup Timing Controller

This block sits beside the issue stage of an out-of-order core. It decides when the dependents of each load should be woken. Up to two loads issue in a cycle. For each one the block either wakes the dependents speculatively, at a fixed load-to-use distance that assumes a first-level cache hit, or holds the load until its hit/miss resolution arrives. A held load wakes its dependents only on a hit. The resolution is presented one cycle before the data returns.

Two policies set the timing. The first is a one-cycle shift applied to the second slot of an issue pair. That slot always wakes one cycle late, so a possible bank collision with the first slot cannot cause a replay. The second is a criticality filter for loads whose hit/miss outcome is uncertain. A per-PC saturating counter is trained at retire, and it decides whether such a load follows a global speculate/hold verdict or simply waits. Loads marked by the external predictor as sure hits always wake speculatively.

Held loads are tracked by tag in a small table. A flush cancels every pending wakeup, both speculative and held. The replay machinery and the register file are outside this block.

Top module: `lwk_wakeup_ctrl`

## Requirements
- R1: After reset every wakeup output is low, and every criticality counter holds 7, which means non-critical.
- R2: An issued load is speculative if its sure-hit input is 1, or if its counter is critical and `glob_spec_i` is 1. Otherwise it is held, and a held load never produces a speculative wakeup.
- R3: A speculative load issued on slot 0 in cycle c raises `swk0_vld_o` for one cycle in cycle c+LTU (default 4), with its tag on `swk0_tag_o`.
- R4: A speculative load issued on slot 1 in cycle c raises `swk1_vld_o` for one cycle in cycle c+LTU+1, with its tag on `swk1_tag_o`. This holds whether or not slot 0 issued in the same cycle.
- R5: Resolution port k (k = 0 or 1) may present, in cycle r, a valid tag that matches a held load with the hit bit at 1. In that case `hwk<k>_vld_o` pulses in cycle r+1 with that tag, and the held entry is released.
- R6: A resolution with the hit bit at 0 releases the matching held entry and produces no wakeup. A resolution whose tag matches no held entry produces no wakeup. This includes loads that were woken speculatively and entries that were already released.
- R7: The counter index is the XOR fold of the PC: PC bit i goes into index bit i mod log2(TBL_ENTRIES). Each counter is 4 bits and unsigned, and a value of 8 or more means critical. A retire update adds 1 when the load completed at the reorder-buffer head and subtracts 1 otherwise. Counters saturate at 0 and 15. An update changes nothing before the next cycle's issue decision.
- R8: A flush in cycle f drops every pending speculative wakeup and every held entry. It also drops any issue or resolution presented in cycle f. No wakeup output is high in cycle f+1.
- R9: Speculative wakeups from both slots and held wakeups that fall due in the same cycle each appear on their own port in that cycle.
- R10: The held table has HELD_DEPTH entries (default 8). A load that would be held while no entry is free wakes speculatively instead. Slot 0 takes the first free entry and slot 1 takes the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Cancel all pending wakeups |
| ld0_vld_i | input | 1 | Slot 0 load issued |
| ld0_pc_i | input | PC_W | Slot 0 load PC |
| ld0_tag_i | input | TAG_W | Slot 0 destination tag |
| ld0_sure_hit_i | input | 1 | Slot 0 predicted certain hit |
| ld1_vld_i | input | 1 | Slot 1 load issued |
| ld1_pc_i | input | PC_W | Slot 1 load PC |
| ld1_tag_i | input | TAG_W | Slot 1 destination tag |
| ld1_sure_hit_i | input | 1 | Slot 1 predicted certain hit |
| glob_spec_i | input | 1 | Global verdict for critical uncertain loads (1 = speculate) |
| res0_vld_i | input | 1 | Resolution port 0 valid |
| res0_hit_i | input | 1 | Resolution port 0 hit |
| res0_tag_i | input | TAG_W | Resolution port 0 tag |
| res1_vld_i | input | 1 | Resolution port 1 valid |
| res1_hit_i | input | 1 | Resolution port 1 hit |
| res1_tag_i | input | TAG_W | Resolution port 1 tag |
| ret_vld_i | input | 1 | Retire-time criticality update valid |
| ret_pc_i | input | PC_W | PC of the retiring load |
| ret_head_i | input | 1 | Load was at reorder-buffer head when it completed |
| swk0_vld_o | output | 1 | Speculative wakeup, slot 0 |
| swk0_tag_o | output | TAG_W | Tag for slot 0 speculative wakeup |
| swk1_vld_o | output | 1 | Speculative wakeup, slot 1 |
| swk1_tag_o | output | TAG_W | Tag for slot 1 speculative wakeup |
| hwk0_vld_o | output | 1 | Held wakeup from resolution port 0 |
| hwk0_tag_o | output | TAG_W | Tag for held wakeup 0 |
| hwk1_vld_o | output | 1 | Held wakeup from resolution port 1 |
| hwk1_tag_o | output | TAG_W | Tag for held wakeup 1 |

## Verification
The speculative paths are delay chains. A stage lost or added shifts the speculative pulse by a cycle, so an error shows at the ports exactly LTU or LTU+1 cycles after the issue. A wrong held-table entry shows one cycle after the matching resolution: the wakeup is missing, duplicated or carries a stale tag. It can also stay hidden until the table fills and a load falls back to speculation too early or too late. A corrupted criticality counter shows only on the next issue from an aliasing PC, as a held load that should have been speculative or the reverse. For that reason the saturation boundaries are probed through the wakeup ports right after training.

// File: rtl/lwk_pkg.sv
package lwk_pkg;
  localparam int CTR_W = 4;
  localparam logic [CTR_W-1:0] CTR_INIT = 4'd7;
  localparam logic [CTR_W-1:0] CTR_MAX  = 4'd15;
  localparam logic [CTR_W-1:0] CTR_MIN  = 4'd0;

  typedef enum logic {WK_HELD = 1'b0, WK_SPEC = 1'b1} wk_mode_e;

  function automatic logic [CTR_W-1:0] ctr_next(input logic [CTR_W-1:0] c, input logic up);
    if (up) return (c == CTR_MAX) ? c : c + 1'b1;
    else    return (c == CTR_MIN) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/lwk_crit_table.sv
module lwk_crit_table import lwk_pkg::*; #(
  parameter int ENTRIES = 1024,
  parameter int PC_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0][PC_W-1:0] rd_pc_i,
  output logic [1:0]           crit_o,
  input  logic                 upd_vld_i,
  input  logic [PC_W-1:0]      upd_pc_i,
  input  logic                 upd_head_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [IDX_W-1:0] upd_idx;

  function automatic logic [IDX_W-1:0] fold(input logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < PC_W; b++) r[b % IDX_W] = r[b % IDX_W] ^ pc[b];
    return r;
  endfunction

  assign upd_idx = fold(upd_pc_i);

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [IDX_W-1:0] rd_idx;
    assign rd_idx    = fold(rd_pc_i[p]);
    assign crit_o[p] = ctr_q[rd_idx][CTR_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (upd_vld_i) begin
      ctr_q[upd_idx] <= ctr_next(ctr_q[upd_idx], upd_head_i);
    end
  end
endmodule

// File: rtl/lwk_delay_line.sv
module lwk_delay_line #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [DEPTH-1:0]            vld_q, vld_prev;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_prev;

  always_comb begin
    vld_prev[0] = vld_i;
    tag_prev[0] = tag_i;
    for (int g = 1; g < DEPTH; g++) begin
      vld_prev[g] = vld_q[g-1];
      tag_prev[g] = tag_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= flush_i ? '0 : vld_prev;
      tag_q <= tag_prev;
    end
  end

  assign vld_o = vld_q[DEPTH-1];
  assign tag_o = tag_q[DEPTH-1];
endmodule

// File: rtl/lwk_held_tracker.sv
module lwk_held_tracker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [1:0]            req_i,
  input  logic [1:0][TAG_W-1:0] tag_i,
  output logic [1:0]            ok_o,
  input  logic [1:0]            res_vld_i,
  input  logic [1:0]            res_hit_i,
  input  logic [1:0][TAG_W-1:0] res_tag_i,
  output logic [1:0]            wk_vld_o,
  output logic [1:0][TAG_W-1:0] wk_tag_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [1:0][DEPTH-1:0]       match;
  logic [1:0]                  any_match;
  logic                        found0, found1;
  logic [IDX_W-1:0]            f0, f1, idx1;
  logic                        use0, use1;
  logic [1:0]                  wk_vld_q;
  logic [1:0][TAG_W-1:0]       wk_tag_q;

  // first and second free entries
  always_comb begin
    found0 = 1'b0; found1 = 1'b0;
    f0 = '0; f1 = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i]) begin
        if (!found0) begin
          found0 = 1'b1; f0 = IDX_W'(i);
        end else if (!found1) begin
          found1 = 1'b1; f1 = IDX_W'(i);
        end
      end
    end
  end

  assign ok_o[0] = found0;
  assign ok_o[1] = req_i[0] ? found1 : found0;
  assign idx1    = req_i[0] ? f1 : f0;
  assign use0    = req_i[0] & ok_o[0];
  assign use1    = req_i[1] & ok_o[1];

  for (genvar p = 0; p < 2; p++) begin : g_res
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign match[p][i] = vld_q[i] & res_vld_i[p] & (tag_q[i] == res_tag_i[p]);
    end
    assign any_match[p] = |match[p];
  end

  always_comb begin
    vld_d = vld_q & ~(match[0] | match[1]);
    tag_d = tag_q;
    if (use0) begin
      vld_d[f0] = 1'b1;
      tag_d[f0] = tag_i[0];
    end
    if (use1) begin
      vld_d[idx1] = 1'b1;
      tag_d[idx1] = tag_i[1];
    end
    if (flush_i) vld_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      tag_q    <= '0;
      wk_vld_q <= '0;
      wk_tag_q <= '0;
    end else begin
      vld_q    <= vld_d;
      tag_q    <= tag_d;
      wk_vld_q <= {2{~flush_i}} & res_vld_i & res_hit_i & any_match;
      wk_tag_q <= res_tag_i;
    end
  end

  assign wk_vld_o = wk_vld_q;
  assign wk_tag_o = wk_tag_q;
endmodule

// File: rtl/lwk_wakeup_ctrl.sv
module lwk_wakeup_ctrl import lwk_pkg::*; #(
  parameter int PC_W        = 32,
  parameter int TAG_W       = 8,
  parameter int LTU         = 4,
  parameter int TBL_ENTRIES = 1024,
  parameter int HELD_DEPTH  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             ld0_vld_i,
  input  logic [PC_W-1:0]  ld0_pc_i,
  input  logic [TAG_W-1:0] ld0_tag_i,
  input  logic             ld0_sure_hit_i,
  input  logic             ld1_vld_i,
  input  logic [PC_W-1:0]  ld1_pc_i,
  input  logic [TAG_W-1:0] ld1_tag_i,
  input  logic             ld1_sure_hit_i,
  input  logic             glob_spec_i,
  input  logic             res0_vld_i,
  input  logic             res0_hit_i,
  input  logic [TAG_W-1:0] res0_tag_i,
  input  logic             res1_vld_i,
  input  logic             res1_hit_i,
  input  logic [TAG_W-1:0] res1_tag_i,
  input  logic             ret_vld_i,
  input  logic [PC_W-1:0]  ret_pc_i,
  input  logic             ret_head_i,
  output logic             swk0_vld_o,
  output logic [TAG_W-1:0] swk0_tag_o,
  output logic             swk1_vld_o,
  output logic [TAG_W-1:0] swk1_tag_o,
  output logic             hwk0_vld_o,
  output logic [TAG_W-1:0] hwk0_tag_o,
  output logic             hwk1_vld_o,
  output logic [TAG_W-1:0] hwk1_tag_o
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]            ld_vld, ld_sure, crit, hold_req, hold_ok, go_spec, spec_vld;
  logic [NSLOT-1:0][PC_W-1:0]  ld_pc;
  logic [NSLOT-1:0][TAG_W-1:0] ld_tag, spec_tag, wk_tag;
  logic [NSLOT-1:0]            res_vld, res_hit, wk_vld;
  logic [NSLOT-1:0][TAG_W-1:0] res_tag;
  wk_mode_e                    mode [NSLOT];

  assign ld_vld  = {ld1_vld_i, ld0_vld_i};
  assign ld_sure = {ld1_sure_hit_i, ld0_sure_hit_i};
  assign ld_pc   = {ld1_pc_i, ld0_pc_i};
  assign ld_tag  = {ld1_tag_i, ld0_tag_i};
  assign res_vld = {res1_vld_i, res0_vld_i};
  assign res_hit = {res1_hit_i, res0_hit_i};
  assign res_tag = {res1_tag_i, res0_tag_i};

  lwk_crit_table #(.ENTRIES(TBL_ENTRIES), .PC_W(PC_W)) u_crit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_pc_i    (ld_pc),
    .crit_o     (crit),
    .upd_vld_i  (ret_vld_i),
    .upd_pc_i   (ret_pc_i),
    .upd_head_i (ret_head_i)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign mode[s]     = (ld_sure[s] | (crit[s] & glob_spec_i)) ? WK_SPEC : WK_HELD;
    assign hold_req[s] = ld_vld[s] & ~flush_i & (mode[s] == WK_HELD);
    // held table full: fall back to speculative wakeup
    assign go_spec[s]  = ld_vld[s] & ~flush_i & ((mode[s] == WK_SPEC) | ~hold_ok[s]);

    // second slot carries one extra cycle of slack
    lwk_delay_line #(.DEPTH(LTU + s), .TAG_W(TAG_W)) u_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush_i),
      .vld_i   (go_spec[s]),
      .tag_i   (ld_tag[s]),
      .vld_o   (spec_vld[s]),
      .tag_o   (spec_tag[s])
    );
  end

  lwk_held_tracker #(.DEPTH(HELD_DEPTH), .TAG_W(TAG_W)) u_held (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .req_i     (hold_req),
    .tag_i     (ld_tag),
    .ok_o      (hold_ok),
    .res_vld_i (res_vld),
    .res_hit_i (res_hit),
    .res_tag_i (res_tag),
    .wk_vld_o  (wk_vld),
    .wk_tag_o  (wk_tag)
  );

  assign swk0_vld_o = spec_vld[0];
  assign swk0_tag_o = spec_tag[0];
  assign swk1_vld_o = spec_vld[1];
  assign swk1_tag_o = spec_tag[1];
  assign hwk0_vld_o = wk_vld[0];
  assign hwk0_tag_o = wk_tag[0];
  assign hwk1_vld_o = wk_vld[1];
  assign hwk1_tag_o = wk_tag[1];
endmodule

// File: rtl/lwk_wakeup_chk.sv
module lwk_wakeup_chk #(
  parameter int LTU   = 4,
  parameter int TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             res0_vld_i,
  input logic             res0_hit_i,
  input logic [TAG_W-1:0] res0_tag_i,
  input logic             res1_vld_i,
  input logic             res1_hit_i,
  input logic [TAG_W-1:0] res1_tag_i,
  input logic             swk0_vld_o,
  input logic             swk1_vld_o,
  input logic             hwk0_vld_o,
  input logic [TAG_W-1:0] hwk0_tag_o,
  input logic             hwk1_vld_o,
  input logic [TAG_W-1:0] hwk1_tag_o
);
  localparam int AGE_W = $clog2(LTU + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_S0  = AGE_W'(LTU);
  localparam logic [AGE_W-1:0] AGE_S1  = AGE_W'(LTU + 1);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != AGE_S1) age_q <= age_q + 1'b1;
  end

  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(swk0_vld_o || swk1_vld_o || hwk0_vld_o || hwk1_vld_o)); // R8

  AST_HELD0_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwk0_vld_o |-> $past(res0_vld_i && res0_hit_i && !flush_i)); // R5

  AST_HELD1_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwk1_vld_o |-> $past(res1_vld_i && res1_hit_i && !flush_i)); // R5

  AST_HELD0_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwk0_vld_o |-> (hwk0_tag_o == $past(res0_tag_i))); // R5

  AST_HELD1_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwk1_vld_o |-> (hwk1_tag_o == $past(res1_tag_i))); // R5

  AST_SLOT0_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swk0_vld_o |-> (age_q >= AGE_S0)); // R3

  AST_SLOT1_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swk1_vld_o |-> (age_q >= AGE_S1)); // R4
endmodule

bind lwk_wakeup_ctrl lwk_wakeup_chk #(.LTU(LTU), .TAG_W(TAG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .res0_vld_i (res0_vld_i),
  .res0_hit_i (res0_hit_i),
  .res0_tag_i (res0_tag_i),
  .res1_vld_i (res1_vld_i),
  .res1_hit_i (res1_hit_i),
  .res1_tag_i (res1_tag_i),
  .swk0_vld_o (swk0_vld_o),
  .swk1_vld_o (swk1_vld_o),
  .hwk0_vld_o (hwk0_vld_o),
  .hwk0_tag_o (hwk0_tag_o),
  .hwk1_vld_o (hwk1_vld_o),
  .hwk1_tag_o (hwk1_tag_o)
);

// File: tb/sim_lwk_wakeup_ctrl.sv
`timescale 1ns/1ps
module sim_lwk_wakeup_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic ld0_vld, ld0_sure, ld1_vld, ld1_sure, glob;
  logic [31:0] ld0_pc, ld1_pc, ret_pc;
  logic [7:0]  ld0_tag, ld1_tag, res0_tag, res1_tag;
  logic res0_vld, res0_hit, res1_vld, res1_hit, ret_vld, ret_head;
  logic swk0_vld, swk1_vld, hwk0_vld, hwk1_vld;
  logic [7:0] swk0_tag, swk1_tag, hwk0_tag, hwk1_tag;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int first_c [4];
  int cnt_c [4];
  logic [7:0] tag_c [4];

  localparam logic [31:0] PC_COLD = 32'h10;
  localparam logic [31:0] PC_CRIT = 32'h20;
  localparam logic [31:0] PC_SAT  = 32'h30;

  always #2.5 clk = ~clk;

  lwk_wakeup_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ld0_vld_i(ld0_vld), .ld0_pc_i(ld0_pc), .ld0_tag_i(ld0_tag), .ld0_sure_hit_i(ld0_sure),
    .ld1_vld_i(ld1_vld), .ld1_pc_i(ld1_pc), .ld1_tag_i(ld1_tag), .ld1_sure_hit_i(ld1_sure),
    .glob_spec_i(glob),
    .res0_vld_i(res0_vld), .res0_hit_i(res0_hit), .res0_tag_i(res0_tag),
    .res1_vld_i(res1_vld), .res1_hit_i(res1_hit), .res1_tag_i(res1_tag),
    .ret_vld_i(ret_vld), .ret_pc_i(ret_pc), .ret_head_i(ret_head),
    .swk0_vld_o(swk0_vld), .swk0_tag_o(swk0_tag), .swk1_vld_o(swk1_vld), .swk1_tag_o(swk1_tag),
    .hwk0_vld_o(hwk0_vld), .hwk0_tag_o(hwk0_tag), .hwk1_vld_o(hwk1_vld), .hwk1_tag_o(hwk1_tag)
  );

  task automatic clr();
    flush = 0; glob = 0;
    ld0_vld = 0; ld0_sure = 0; ld0_pc = 0; ld0_tag = 0;
    ld1_vld = 0; ld1_sure = 0; ld1_pc = 0; ld1_tag = 0;
    res0_vld = 0; res0_hit = 0; res0_tag = 0;
    res1_vld = 0; res1_hit = 0; res1_tag = 0;
    ret_vld = 0; ret_pc = 0; ret_head = 0;
  endtask

  task automatic obs_clear();
    cyc = 0;
    for (int k = 0; k < 4; k++) begin first_c[k] = 0; cnt_c[k] = 0; tag_c[k] = 0; end
  endtask

  task automatic step();
    logic [3:0] v;
    logic [7:0] t [4];
    @(posedge clk); #1;
    cyc++;
    v = {hwk1_vld, hwk0_vld, swk1_vld, swk0_vld};
    t[0] = swk0_tag; t[1] = swk1_tag; t[2] = hwk0_tag; t[3] = hwk1_tag;
    for (int k = 0; k < 4; k++) begin
      if (v[k]) begin
        cnt_c[k]++;
        if (first_c[k] == 0) begin first_c[k] = cyc; tag_c[k] = t[k]; end
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // exp_first == 0 means the port must stay silent
  task automatic expect_port(input int k, input string req, input int exp_first, input logic [7:0] exp_tag);
    if (exp_first == 0) begin
      check(cnt_c[k] == 0, req, $sformatf("port%0d pulse count", k), cnt_c[k], 0);
    end else begin
      check(first_c[k] == exp_first, req, $sformatf("port%0d wake cycle", k), first_c[k], exp_first);
      check(tag_c[k] == exp_tag, req, $sformatf("port%0d wake tag", k), tag_c[k], exp_tag);
      check(cnt_c[k] == 1, req, $sformatf("port%0d pulse count", k), cnt_c[k], 1);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic head, input int n);
    for (int i = 0; i < n; i++) begin
      ret_vld = 1; ret_pc = pc; ret_head = head;
      step();
      clr();
    end
  endtask

  // uncertain load on slot 0; observe speculative vs held behaviour
  task automatic probe(input logic [31:0] pc, input logic g, input logic exp_spec,
                       input logic [7:0] tg, input string req);
    clr();
    ld0_vld = 1; ld0_pc = pc; ld0_tag = tg; ld0_sure = 0; glob = g;
    obs_clear(); step(); clr(); run(6);
    if (exp_spec) begin
      expect_port(0, req, 4, tg);
    end else begin
      expect_port(0, req, 0, 8'h0);
      obs_clear();
      res0_vld = 1; res0_hit = 1; res0_tag = tg;
      step(); clr(); run(1);
      expect_port(2, req, 1, tg);
    end
  endtask

  task automatic t_reset();
    check(swk0_vld == 0, "R1", "swk0 after reset", swk0_vld, 0);
    check(swk1_vld == 0, "R1", "swk1 after reset", swk1_vld, 0);
    check(hwk0_vld == 0, "R1", "hwk0 after reset", hwk0_vld, 0);
    check(hwk1_vld == 0, "R1", "hwk1 after reset", hwk1_vld, 0);
    probe(PC_COLD, 1'b1, 1'b0, 8'h05, "R1");
  endtask

  task automatic t_spec_slot0();
    clr(); ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h11; ld0_sure = 1;
    obs_clear(); step(); clr(); run(7);
    expect_port(0, "R3", 4, 8'h11);
    expect_port(1, "R3", 0, 8'h0);
    expect_port(2, "R3", 0, 8'h0);
    // resolution for a speculatively woken load is ignored
    obs_clear(); res0_vld = 1; res0_hit = 1; res0_tag = 8'h11;
    step(); clr(); run(2);
    expect_port(2, "R6", 0, 8'h0);
  endtask

  task automatic t_pair();
    clr();
    ld0_vld = 1; ld0_tag = 8'h21; ld0_sure = 1;
    ld1_vld = 1; ld1_tag = 8'h22; ld1_sure = 1;
    obs_clear(); step(); clr(); run(7);
    expect_port(0, "R3", 4, 8'h21);
    expect_port(1, "R4", 5, 8'h22);
    clr(); ld1_vld = 1; ld1_tag = 8'h23; ld1_sure = 1;
    obs_clear(); step(); clr(); run(7);
    expect_port(1, "R4", 5, 8'h23);
    expect_port(0, "R4", 0, 8'h0);
  endtask

  task automatic t_held();
    clr(); glob = 1;
    ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h31;
    ld1_vld = 1; ld1_pc = PC_COLD; ld1_tag = 8'h32;
    obs_clear(); step(); clr(); run(8);
    expect_port(0, "R2", 0, 8'h0);
    expect_port(1, "R2", 0, 8'h0);
    obs_clear();
    res0_vld = 1; res0_hit = 0; res0_tag = 8'h31;
    res1_vld = 1; res1_hit = 1; res1_tag = 8'h32;
    step(); clr(); run(2);
    expect_port(3, "R5", 1, 8'h32);
    expect_port(2, "R6", 0, 8'h0);
    obs_clear(); res0_vld = 1; res0_hit = 1; res0_tag = 8'h31;
    step(); clr(); run(2);
    expect_port(2, "R6", 0, 8'h0);
  endtask

  task automatic t_crit();
    train(PC_CRIT, 1'b1, 1);
    probe(PC_CRIT, 1'b1, 1'b1, 8'h51, "R7");
    probe(PC_CRIT, 1'b0, 1'b0, 8'h52, "R2");
    train(PC_CRIT, 1'b0, 1);
    probe(PC_CRIT, 1'b1, 1'b0, 8'h53, "R7");
  endtask

  task automatic t_sat();
    train(PC_SAT, 1'b1, 12);
    train(PC_SAT, 1'b0, 7);
    probe(PC_SAT, 1'b1, 1'b1, 8'h61, "R7");
    train(PC_SAT, 1'b0, 1);
    probe(PC_SAT, 1'b1, 1'b0, 8'h62, "R7");
    train(PC_SAT, 1'b0, 10);
    train(PC_SAT, 1'b1, 7);
    probe(PC_SAT, 1'b1, 1'b0, 8'h63, "R7");
    train(PC_SAT, 1'b1, 1);
    probe(PC_SAT, 1'b1, 1'b1, 8'h64, "R7");
  endtask

  task automatic t_flush();
    clr();
    ld0_vld = 1; ld0_tag = 8'h41; ld0_sure = 1;
    ld1_vld = 1; ld1_pc = PC_COLD; ld1_tag = 8'h42; glob = 1;
    obs_clear(); step(); clr(); step();
    flush = 1; step(); clr(); run(6);
    res1_vld = 1; res1_hit = 1; res1_tag = 8'h42;
    step(); clr(); run(2);
    expect_port(0, "R8", 0, 8'h0);
    expect_port(1, "R8", 0, 8'h0);
    expect_port(3, "R8", 0, 8'h0);
    clr(); flush = 1; ld0_vld = 1; ld0_tag = 8'h43; ld0_sure = 1;
    obs_clear(); step(); clr(); run(7);
    expect_port(0, "R8", 0, 8'h0);
  endtask

  task automatic t_coincide();
    clr(); glob = 1;
    ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h70;
    ld1_vld = 1; ld1_tag = 8'h71; ld1_sure = 1;
    obs_clear(); step(); clr();
    ld0_vld = 1; ld0_tag = 8'h72; ld0_sure = 1;
    step(); clr(); run(2);
    res0_vld = 1; res0_hit = 1; res0_tag = 8'h70;
    step(); clr(); run(3);
    expect_port(0, "R9", 5, 8'h72);
    expect_port(1, "R9", 5, 8'h71);
    expect_port(2, "R9", 5, 8'h70);
  endtask

  task automatic t_full();
    clr(); obs_clear();
    for (int i = 0; i < 3; i++) begin
      glob = 1;
      ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h80 + 8'(2*i);
      ld1_vld = 1; ld1_pc = PC_COLD; ld1_tag = 8'h81 + 8'(2*i);
      step(); clr();
    end
    glob = 1; ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h86;
    step(); clr(); run(6);
    expect_port(0, "R10", 0, 8'h0);
    expect_port(1, "R10", 0, 8'h0);
    // one entry left: slot 0 takes it, slot 1 falls back
    glob = 1;
    ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h88;
    ld1_vld = 1; ld1_pc = PC_COLD; ld1_tag = 8'h89;
    obs_clear(); step(); clr();
    glob = 1; ld0_vld = 1; ld0_pc = PC_COLD; ld0_tag = 8'h8A;
    step(); clr(); run(6);
    expect_port(1, "R10", 5, 8'h89);
    expect_port(0, "R10", 5, 8'h8A);
    obs_clear();
    for (int i = 0; i < 8; i++) begin
      res0_vld = 1; res0_hit = 1;
      res0_tag = (i == 7) ? 8'h88 : 8'h80 + 8'(i);
      step(); clr();
    end
    run(2);
    check(cnt_c[2] == 8, "R10", "held wakes after drain", cnt_c[2], 8);
    probe(PC_COLD, 1'b1, 1'b0, 8'h8B, "R10");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_spec_slot0();
    t_pair();
    t_held();
    t_crit();
    t_sat();
    t_flush();
    t_coincide();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule